// File: doc/BRIEF.md
# Banked serial register loader

This block is a write-only three-wire serial slave that fills a file of 27 eight-bit configuration registers. An external host holds the load strobe low, clocks bytes in least significant bit first on the serial clock, and releases the strobe to make the new values take effect. Every burst opens with the byte for address 0. Bit 0 of that byte picks the register bank, and so the address where the automatic increment goes on.

Received bytes wait in shadow storage. All bytes received in a burst are copied into the active registers together when the strobe rises. Registers the burst did not touch keep their values. The serial pins are brought into the system clock domain through synchronizer flops, and all edges are found on the synchronized copies. An asynchronous active-low reset puts every register back to its default.

Top module: `cfgLoader`

## Requirements
- R1: A data bit is taken only on a rising edge of `sClk` seen while `sLoadN` is low. Serial clock edges while `sLoadN` is high change no register and do not disturb the next burst.
- R2: Each byte is exactly 8 bits, and the first bit shifted in becomes bit 0 of the register.
- R3: The first complete byte after a falling edge of `sLoadN` is stored at address 0.
- R4: If bit 0 of the address-0 byte is 0, the next byte goes to address 1 (bank 1, addresses 0 to 13). If it is 1, the next byte goes to address 14 (bank 2, addresses 14 to 26). After that each byte goes to the previous address plus one.
- R5: Once a byte has been stored at address 26, later bytes in the same burst are dropped. No address wraps around.
- R6: Bytes go to shadow storage, and `cfgOut` does not change while a burst is in progress. Counting the first `clk` edge that samples `sLoadN` high as edge 1, all bytes of the burst appear in `cfgOut` together at edge 3.
- R7: Addresses 24, 25 and 26, and bits 7:4 of addresses 8, 10 and 12, always read 0 whatever is written to them.
- R8: When a burst ends partway through a byte, that partial byte is dropped. The completed bytes before it are still committed.
- R9: While `rstN` is low, every register holds its default. Addresses 7, 9, 11 and 13 hold 0x40, 14 holds 0x33, 16 and 18 hold 24, 19 holds 0x77, 21 and 22 hold 32, and all others hold 0.
- R10: A register not written in a burst keeps its value through that burst's commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the register file and synchronizers |
| rstN | input | 1 | Asynchronous active-low reset to register defaults |
| sClk | input | 1 | Serial clock; data taken on its rising edge |
| sLoadN | input | 1 | Active-low load strobe; its rising edge commits the burst |
| sData | input | 1 | Serial data, least significant bit first |
| cfgOut | output | 216 | Active registers, address i in bits [8*i+7:8*i] |

## Verification
On every cycle the assertions check that the active registers hold still unless a commit strobe is present, that the test fields stay zero, that a burst always begins at address 0, that the address after address 0 is 1 or 14 as bit 0 dictates, and that no write goes beyond the last address. Only the bench scenarios can show the order of bits within a byte, the three-edge commit latency, that bytes past the top address are dropped rather than wrapped, that partial bytes and stray serial clocks are discarded, and that unwritten registers survive a commit. A behavioural model compares all 27 registers on every clock.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  localparam int NUM_REGS   = 27;
  localparam int REG_W      = 8;
  localparam int BANK2_BASE = 14;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int BIT_CNT_W  = $clog2(REG_W);
  localparam int OUT_W      = NUM_REGS * REG_W;

  // Strobes from the serial control to the register datapath
  typedef struct packed {
    logic              burstStart;
    logic              byteWr;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
    logic              commit;
  } ldStrobe_t;

  function automatic logic [REG_W-1:0] regDefault(input int idx);
    case (idx)
      7, 9, 11, 13: return 8'h40;
      14:           return 8'h33;
      16, 18:       return 8'd24;
      19:           return 8'h77;
      21, 22:       return 8'd32;
      default:      return '0;
    endcase
  endfunction

  // Bits that may be written; locked test fields are cleared
  function automatic logic [REG_W-1:0] regWriteMask(input int idx);
    if (idx >= 24) return '0;
    if (idx == 8 || idx == 10 || idx == 12) return 8'h0F;
    return '1;
  endfunction
endpackage

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfgload_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sClk,
  input  logic      sLoadN,
  input  logic      sData,
  output ldStrobe_t strb
);
  localparam logic [ADDR_W-1:0]    LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0]    BANK2     = ADDR_W'(BANK2_BASE);
  localparam logic [ADDR_W-1:0]    BANK1     = ADDR_W'(1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(REG_W - 1);

  logic [SYNC_STAGES-1:0] clkSync, loadSync, dataSync;
  logic clkPrev, loadPrev;
  logic clkS, loadS, dataS;
  logic sClkRise, loadFall, loadRise, byteDone;

  logic [REG_W-1:0]     shiftReg;
  logic [REG_W-1:0]     fullByte;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [ADDR_W-1:0]    curAddr;
  logic                 halted;

  // Synchronizers and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      loadSync <= '1;
      dataSync <= '0;
      clkPrev  <= 1'b0;
      loadPrev <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], sClk};
      loadSync <= {loadSync[SYNC_STAGES-2:0], sLoadN};
      dataSync <= {dataSync[SYNC_STAGES-2:0], sData};
      clkPrev  <= clkS;
      loadPrev <= loadS;
    end
  end

  assign clkS     = clkSync[SYNC_STAGES-1];
  assign loadS    = loadSync[SYNC_STAGES-1];
  assign dataS    = dataSync[SYNC_STAGES-1];
  assign sClkRise = clkS & ~clkPrev;
  assign loadFall = ~loadS & loadPrev;
  assign loadRise = loadS & ~loadPrev;
  assign fullByte = {dataS, shiftReg[REG_W-1:1]};
  assign byteDone = sClkRise && !loadS && (bitCnt == LAST_BIT);

  // Bit counter, byte assembly and address sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      curAddr  <= '0;
      halted   <= 1'b0;
    end else if (loadFall) begin
      bitCnt  <= '0;
      curAddr <= '0;
      halted  <= 1'b0;
    end else if (sClkRise && !loadS) begin
      shiftReg <= fullByte;
      if (byteDone) begin
        bitCnt <= '0;
        if (!halted) begin
          if (curAddr == LAST_ADDR)  halted  <= 1'b1;
          else if (curAddr == '0)    curAddr <= fullByte[0] ? BANK2 : BANK1;
          else                       curAddr <= curAddr + 1'b1;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.burstStart = loadFall;
    strb.byteWr     = byteDone && !halted;
    strb.addr       = curAddr;
    strb.data       = fullByte;
    strb.commit     = loadRise;
  end

  // R4: bank select decides the address following address 0
  p_bank_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteWr && strb.addr == '0) |=>
      (curAddr == ($past(fullByte[0]) ? BANK2 : BANK1)));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgload_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ldStrobe_t        strb,
  output logic [OUT_W-1:0] cfgOut
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = regWriteMask(i);
    localparam logic [REG_W-1:0] DEF  = regDefault(i);
    logic [REG_W-1:0] shadowQ, activeQ;
    logic             pendQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ <= '0;
        pendQ   <= 1'b0;
        activeQ <= DEF;
      end else if (strb.burstStart) begin
        pendQ <= 1'b0;
      end else if (strb.byteWr && strb.addr == ADDR_W'(i)) begin
        shadowQ <= strb.data & MASK;
        pendQ   <= 1'b1;
      end else if (strb.commit) begin
        pendQ <= 1'b0;
        if (pendQ) activeQ <= shadowQ;
      end
    end

    assign cfgOut[i*REG_W +: REG_W] = activeQ;
  end

  // R6: active registers move only on a commit
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cfgOut));

  // R6: a commit never coincides with a byte write
  p_commit_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !strb.byteWr);

  // R7: locked test fields stay zero
  p_test_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOut[24*REG_W +: 3*REG_W] == '0) &&
    (cfgOut[8*REG_W+4 +: 4] == '0) &&
    (cfgOut[10*REG_W+4 +: 4] == '0) &&
    (cfgOut[12*REG_W+4 +: 4] == '0));

  // R3: every burst starts at address 0
  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.burstStart |=> (strb.addr == '0));

  // R5: no write beyond the top address
  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWr |-> (strb.addr <= ADDR_W'(NUM_REGS - 1)));
endmodule

// File: rtl/cfgLoader.sv
module cfgLoader
  import cfgload_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sClk,
  input  logic             sLoadN,
  input  logic             sData,
  output logic [OUT_W-1:0] cfgOut
);
  ldStrobe_t strb;

  cfg_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sClk   (sClk),
    .sLoadN (sLoadN),
    .sData  (sData),
    .strb   (strb)
  );

  cfg_regfile u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfgOut (cfgOut)
  );
endmodule

// File: tb/sim_cfgLoader.sv
module sim_cfgLoader;
  localparam int NREG = 27;

  logic clk = 1'b0;
  logic rstN, sClk, sLoadN, sData;
  logic [NREG*8-1:0] cfgOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  cfgLoader u0 (
    .clk(clk), .rstN(rstN), .sClk(sClk), .sLoadN(sLoadN),
    .sData(sData), .cfgOut(cfgOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic int defVal(input int idx);
    if (idx == 7 || idx == 9 || idx == 11 || idx == 13) return 'h40;
    if (idx == 14) return 'h33;
    if (idx == 16 || idx == 18) return 24;
    if (idx == 19) return 'h77;
    if (idx == 21 || idx == 22) return 32;
    return 0;
  endfunction

  function automatic int maskVal(input int idx);
    if (idx >= 24) return 0;
    if (idx == 8 || idx == 10 || idx == 12) return 'h0F;
    return 'hFF;
  endfunction

  // Behavioural reference model
  int expReg[NREG];
  int shadowM[NREG];
  bit pendM[NREG];
  bit hClk[4];
  bit hLoad[4];
  bit hData[4];
  int bitCount, acc, addrM;
  bit stopped;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) begin
        expReg[i] = defVal(i); pendM[i] = 0; shadowM[i] = 0;
      end
      for (int k = 0; k < 4; k++) begin
        hClk[k] = 0; hLoad[k] = 1; hData[k] = 0;
      end
      bitCount = 0; acc = 0; addrM = 0; stopped = 0;
    end else begin
      for (int k = 3; k > 0; k--) begin
        hClk[k] = hClk[k-1]; hLoad[k] = hLoad[k-1]; hData[k] = hData[k-1];
      end
      hClk[0] = sClk; hLoad[0] = sLoadN; hData[0] = sData;
      if (hLoad[3] && !hLoad[2]) begin
        bitCount = 0; acc = 0; addrM = 0; stopped = 0;
        for (int i = 0; i < NREG; i++) pendM[i] = 0;
      end else if (hClk[2] && !hClk[3] && !hLoad[2]) begin
        acc = acc | (int'(hData[2]) << bitCount);
        bitCount++;
        if (bitCount == 8) begin
          if (!stopped) begin
            shadowM[addrM] = acc & maskVal(addrM);
            pendM[addrM] = 1;
            if (addrM == NREG - 1) stopped = 1;
            else if (addrM == 0) addrM = (acc & 1) ? 14 : 1;
            else addrM++;
          end
          bitCount = 0; acc = 0;
        end
      end else if (hLoad[2] && !hLoad[3]) begin
        for (int i = 0; i < NREG; i++) begin
          if (pendM[i]) expReg[i] = shadowM[i];
          pendM[i] = 0;
        end
      end
    end
  end

  // Compare every register on every clock (R6 timing, all values)
  always @(negedge clk) begin
    if (rstN) begin
      bit bad;
      bad = 0;
      for (int i = 0; i < NREG; i++)
        if (int'(cfgOut[i*8 +: 8]) != expReg[i]) bad = 1;
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL R6 cycle compare t=%0t actual=%h expected model mismatch", $time, cfgOut);
      end
    end
  end

  task automatic checkReg(input int idx, input int exp, input string tag);
    int act;
    act = int'(cfgOut[idx*8 +: 8]);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, idx, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    sData = b; sClk = 1'b0; waitN(3);
    sClk = 1'b1; waitN(3);
  endtask

  task automatic sendByte(input int b);
    for (int k = 0; k < 8; k++) sendBit(b[k]);
  endtask

  task automatic startBurst();
    sLoadN = 1'b0; waitN(3);
  endtask

  task automatic endBurst();
    sClk = 1'b0; waitN(3);
    sLoadN = 1'b1; waitN(6);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sClk = 1'b0; sLoadN = 1'b1; sData = 1'b0;
    waitN(5);
    checkReg(7, 'h40, "R9");
    checkReg(16, 24, "R9");
    checkReg(19, 'h77, "R9");
    rstN = 1'b1; waitN(2);
    checkReg(22, 32, "R9");

    // Bank 1 burst
    startBurst();
    sendByte('h00); sendByte('hA1); sendByte('hA2); sendByte('hA3);
    waitN(4);
    checkReg(1, 0, "R6");
    endBurst();
    checkReg(0, 'h00, "R3");
    checkReg(1, 'hA1, "R4");
    checkReg(2, 'hA2, "R2");
    checkReg(3, 'hA3, "R4");

    // Bank 2 burst
    startBurst();
    sendByte('h01); sendByte('h5C); sendByte('h11);
    endBurst();
    checkReg(0, 'h01, "R4");
    checkReg(14, 'h5C, "R4");
    checkReg(15, 'h11, "R4");
    checkReg(1, 'hA1, "R10");
    checkReg(7, 'h40, "R10");

    // Test fields in bank 1
    startBurst();
    sendByte('h00);
    for (int a = 1; a <= 12; a++) sendByte('hFF);
    endBurst();
    checkReg(8, 'h0F, "R7");
    checkReg(12, 'h0F, "R7");
    checkReg(7, 'hFF, "R7");
    checkReg(13, 'h40, "R10");

    // Bank 2 to the top and past it
    startBurst();
    sendByte('h01);
    for (int a = 14; a <= 26; a++) sendByte('hEE);
    sendByte('h99); sendByte('h99);
    endBurst();
    checkReg(24, 0, "R7");
    checkReg(26, 0, "R7");
    checkReg(23, 'hEE, "R5");
    checkReg(14, 'hEE, "R5");
    checkReg(0, 'h01, "R5");

    // Partial byte at the end of a burst
    startBurst();
    sendByte('h00); sendByte('h77);
    for (int k = 0; k < 5; k++) sendBit(1'b1);
    endBurst();
    checkReg(1, 'h77, "R8");
    checkReg(2, 'hFF, "R8");
    checkReg(0, 'h00, "R8");

    // Serial clocks with the strobe high
    for (int k = 0; k < 16; k++) sendBit(1'b0);
    sClk = 1'b0; waitN(4);
    checkReg(1, 'h77, "R1");
    startBurst();
    sendByte('h00); sendByte('h12);
    endBurst();
    checkReg(1, 'h12, "R1");

    // Bit order and commit latency
    startBurst();
    sendByte('h00); sendByte('h34); sendByte('h80);
    sClk = 1'b0; waitN(3);
    sLoadN = 1'b1;
    waitN(2);
    checkReg(1, 'h12, "R6");
    waitN(1);
    checkReg(1, 'h34, "R6");
    checkReg(2, 'h80, "R2");
    waitN(4);

    // Reset restores defaults
    rstN = 1'b0; waitN(2);
    checkReg(1, 0, "R9");
    checkReg(9, 'h40, "R9");
    checkReg(14, 'h33, "R9");
    rstN = 1'b1; waitN(4);
    checkReg(21, 32, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule